// File: doc/BRIEF.md
# Timing Reference Widening Converter

This block sits in a parallel video path ahead of a serialiser. It accepts one word per clock when `in_valid` is high. A word is either native 10-bit data or 8-bit data carried on bits 9:2, with bits 1:0 tied low. It returns a 10-bit stream in which the 8-bit timing reference (FF, 00, 00) has become the 10-bit reference (3FF, 000, 000). Because the all-ones word can only be recognised by what follows it, every word passes through a three-word delay line. When the two newest words are both zero and the word ahead of them has bits 9:2 all set, that word leaves with its two low bits forced to one.

The block also flags an illegal run of zero words. Zero words are reserved for timing references, and the longest legal run depends on which video standard `std_sel` selects. A one-cycle `sync_found` pulse marks the first zero word of every reference as it leaves.

Top module: `trs_word_conv`

## Requirements
- R1: A clock edge with `rst` high clears the delay line. After that edge `out_word` is 000, and `out_valid`, `sync_found` and `zrun_err` are low.
- R2: `out_valid` is high only in the cycle after an accepted word (`in_valid` high, `rst` low). It stays low for the first two words accepted after reset and is high after the third and every later one.
- R3: When word n+2 (counted from reset) is accepted, `out_word` shows accepted word n in the following cycle. Apart from the rule in R5, the word is unchanged.
- R4: A cycle with `in_valid` low is ignored. In the cycle that follows, `out_word` keeps its value, `out_valid` is low, and `in_word` does not reach the stream.
- R5: An accepted word whose bits 9:2 are all one, followed by two accepted words equal to 000, leaves with bits 1:0 set to 11. For example, 3FC becomes 3FF.
- R6: A word with bits 9:2 all one is output unchanged when the two accepted words after it are not both 000. Words whose bits 9:2 are not all one are never altered.
- R7: A native 3FF word passes through as 3FF, whether or not zero words follow it.
- R8: `sync_found` is high for exactly one cycle, together with `out_valid`. That cycle is the one in which `out_word` shows the first 000 word that follows a word handled by R5 (bits 9:2 all one, then 000, 000). It is low at all other times.
- R9: With `std_sel` = 0, `zrun_err` is high in the cycle after each accepted 000 word that makes the run of consecutive accepted 000 words longer than 3.
- R10: With `std_sel` = 1, `zrun_err` is high in the cycle after each accepted 000 word that makes the run of consecutive accepted 000 words longer than 4.
- R11: An accepted nonzero word ends a zero run. A cycle with `in_valid` low does not end a zero run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| in_word | input | 10 | Incoming word; 8-bit data on bits 9:2 with bits 1:0 low |
| in_valid | input | 1 | Marks `in_word` as a word to accept this cycle |
| std_sel | input | 1 | Zero-run limit select: 0 allows 3 zero words, 1 allows 4 |
| out_word | output | 10 | Delayed word, corrected where R5 applies |
| out_valid | output | 1 | Pulses for each word presented on `out_word` |
| sync_found | output | 1 | Pulses with the first 000 word of a detected reference |
| zrun_err | output | 1 | Pulses after a zero word that exceeds the run limit |

## Verification
The assertions assume that `rst` is high at the first clock edge. They also assume that `in_valid`, `in_word` and `std_sel` hold known values at every edge after that, since each property is read from the values sampled at the edge. The stimulus starts with reset held and drives every input from the falling edge on. It also asserts reset again in mid-stream, with a valid word that looks like a reference present, to show that reset takes priority over an accepted word. The sweeps put every 10-bit value in front of a zero pair. They then mix zeros, gaps and near-reference words, and finally walk zero runs of one to six words through both limit settings, with gaps placed inside some of the runs.

// File: rtl/trs_conv_pkg.sv
package trs_conv_pkg;

    // Words held in the delay line: the candidate word plus the two that must follow it
    localparam int unsigned PIPE_DEPTH = 3;

    // Low bits forced to one when an 8-bit all-ones word is widened
    localparam int unsigned FIX_LSBS = 2;

    // Zero-run limit selection
    typedef enum logic {
        RUN_LIMIT_A = 1'b0,
        RUN_LIMIT_B = 1'b1
    } run_sel_e;

endpackage

// File: rtl/trs_delay_line.sv
module trs_delay_line
    import trs_conv_pkg::*;
#(
    parameter int unsigned WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic              dout_valid,
    output logic              ref_mark
);

    localparam int unsigned D      = PIPE_DEPTH;
    localparam int unsigned FILL_W = $clog2(D + 1);
    localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(D - 1);

    typedef struct packed {
        logic [D-1:0][WORD_W-1:0] stage;
        logic [FILL_W-1:0]        fill;
        logic                     pend;
        logic                     vld;
        logic                     mark;
    } dl_state_t;

    dl_state_t st_d, st_q;
    logic      tail_zero;
    logic      hit;

    always_comb begin
        tail_zero = (din == '0);
        for (int i = 0; i < int'(D) - 2; i++) begin
            if (st_q.stage[i] != '0) begin
                tail_zero = 1'b0;
            end
        end
        hit = shift && tail_zero && (&st_q.stage[D-2][WORD_W-1:FIX_LSBS]);

        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.mark = 1'b0;
        if (shift) begin
            st_d.stage[0] = din;
            for (int i = 1; i < int'(D); i++) begin
                st_d.stage[i] = st_q.stage[i-1];
            end
            if (hit) begin
                st_d.stage[D-1][FIX_LSBS-1:0] = '1;
            end
            st_d.vld  = (st_q.fill == FILL_MAX);
            st_d.mark = st_q.pend;
            st_d.pend = hit;
            if (st_q.fill != FILL_MAX) begin
                st_d.fill = st_q.fill + 1'b1;
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout       = st_q.stage[D-1];
    assign dout_valid = st_q.vld;
    assign ref_mark   = st_q.mark;

    // R2: a presented word always follows an accepted one
    a_r2_valid_after_accept: assert property (@(posedge clk) disable iff (rst)
        st_q.vld |-> $past(shift));

    // R5: a reference head moving to the output gains its low bits
    a_r5_fix_lsbs: assert property (@(posedge clk) disable iff (rst)
        (shift && din == '0 && st_q.stage[0] == '0 && (&st_q.stage[1][WORD_W-1:FIX_LSBS]))
        |=> (&st_q.stage[D-1][FIX_LSBS-1:0]));

    // R8: the reference mark only rides on a presented zero word
    a_r8_sync_on_zero: assert property (@(posedge clk) disable iff (rst)
        st_q.mark |-> (st_q.vld && st_q.stage[D-1] == '0));

endmodule

// File: rtl/trs_zero_run.sv
module trs_zero_run
    import trs_conv_pkg::*;
#(
    parameter int unsigned LIM_A = 3,
    parameter int unsigned LIM_B = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic shift,
    input  logic is_zero,
    input  logic std_sel,
    output logic run_err
);

    localparam int unsigned LMAX  = (LIM_A > LIM_B) ? LIM_A : LIM_B;
    localparam int unsigned CNT_W = $clog2(LMAX + 2);
    localparam logic [CNT_W-1:0] SAT   = CNT_W'(LMAX + 1);
    localparam logic [CNT_W-1:0] LIM_A_C = CNT_W'(LIM_A);
    localparam logic [CNT_W-1:0] LIM_B_C = CNT_W'(LIM_B);

    typedef struct packed {
        logic [CNT_W-1:0] run;
        logic             err;
    } zr_state_t;

    zr_state_t        st_d, st_q;
    run_sel_e         sel;
    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] run_inc;

    always_comb begin
        sel     = run_sel_e'(std_sel);
        lim     = (sel == RUN_LIMIT_B) ? LIM_B_C : LIM_A_C;
        run_inc = (st_q.run == SAT) ? st_q.run : st_q.run + 1'b1;

        st_d     = st_q;
        st_d.err = 1'b0;
        if (shift) begin
            if (is_zero) begin
                st_d.run = run_inc;
                st_d.err = (run_inc > lim);
            end else begin
                st_d.run = '0;
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign run_err = st_q.err;

    // R9: an error only follows an accepted zero word
    a_r9_err_needs_zero: assert property (@(posedge clk) disable iff (rst)
        st_q.err |-> $past(shift && is_zero));

endmodule

// File: rtl/trs_word_conv.sv
module trs_word_conv
    import trs_conv_pkg::*;
#(
    parameter int unsigned WORD_W     = 10,
    parameter int unsigned ZRUN_LIM_A = 3,
    parameter int unsigned ZRUN_LIM_B = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_valid,
    input  logic              std_sel,
    output logic [WORD_W-1:0] out_word,
    output logic              out_valid,
    output logic              sync_found,
    output logic              zrun_err
);

    logic accept;
    logic in_is_zero;

    assign accept     = in_valid && !rst;
    assign in_is_zero = (in_word == '0);

    trs_delay_line #(
        .WORD_W (WORD_W)
    ) u_line (
        .clk        (clk),
        .rst        (rst),
        .shift      (accept),
        .din        (in_word),
        .dout       (out_word),
        .dout_valid (out_valid),
        .ref_mark   (sync_found)
    );

    trs_zero_run #(
        .LIM_A (ZRUN_LIM_A),
        .LIM_B (ZRUN_LIM_B)
    ) u_run (
        .clk     (clk),
        .rst     (rst),
        .shift   (accept),
        .is_zero (in_is_zero),
        .std_sel (std_sel),
        .run_err (zrun_err)
    );

    // R1: reset leaves every output quiet
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !sync_found && !zrun_err && out_word == '0));

    // R4: an idle cycle neither moves nor presents a word
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(in_valid) && !$past(rst)) |-> ($stable(out_word) && !out_valid));

endmodule

// File: tb/tb_trs_word_conv.sv
`timescale 1ns/1ps
module tb_trs_word_conv;

    logic       clk = 1'b0;
    logic       rst;
    logic [9:0] in_word;
    logic       in_valid;
    logic       std_sel;
    logic [9:0] out_word;
    logic       out_valid;
    logic       sync_found;
    logic       zrun_err;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done     = 0;

    // model state
    int       acc;
    int       run;
    bit       gap;
    logic [9:0] h0, h1, h2, h3;
    logic [9:0] exp_word;

    always #10 clk = ~clk;

    trs_word_conv dut (
        .clk        (clk),
        .rst        (rst),
        .in_word    (in_word),
        .in_valid   (in_valid),
        .std_sel    (std_sel),
        .out_word   (out_word),
        .out_valid  (out_valid),
        .sync_found (sync_found),
        .zrun_err   (zrun_err)
    );

    task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic step(input bit r, input bit v, input logic [9:0] w, input bit s);
        bit   ev, es, ee, fix;
        int   lim;
        string wtag;
        @(negedge clk);
        rst = r; in_valid = v; in_word = w; std_sel = s;
        @(posedge clk);
        #5;
        ev = 0; es = 0; ee = 0; wtag = "R4";
        lim = s ? 4 : 3;
        if (r) begin
            acc = 0; run = 0; gap = 0;
            h0 = '0; h1 = '0; h2 = '0; h3 = '0; exp_word = '0;
            chk("R1", {9'b0, out_valid}, 10'd0);
            chk("R1", {9'b0, sync_found}, 10'd0);
            chk("R1", {9'b0, zrun_err}, 10'd0);
            chk("R1", out_word, 10'd0);
            return;
        end
        if (v) begin
            h3 = h2; h2 = h1; h1 = h0; h0 = w;
            acc++;
            wtag = "R3";
            if (acc >= 3) begin
                ev  = 1;
                fix = (h1 == 10'd0) && (h0 == 10'd0) && (&h2[9:2]);
                exp_word = fix ? (h2 | 10'h003) : h2;
                es  = (acc >= 4) && (h2 == 10'd0) && (h1 == 10'd0) && (&h3[9:2]);
                if (h2 == 10'h3FF)            wtag = "R7";
                else if (fix)                 wtag = "R5";
                else if (&h2[9:2])            wtag = "R6";
            end
            if (w == 10'd0) begin
                run++;
                ee = (run > lim);
            end else begin
                run = 0;
                gap = 0;
            end
            chk("R2", {9'b0, out_valid}, {9'b0, ev});
            chk(gap ? "R11" : (s ? "R10" : "R9"), {9'b0, zrun_err}, {9'b0, ee});
        end else begin
            if (run > 0) gap = 1;
            chk("R4", {9'b0, out_valid}, 10'd0);
            chk("R4", {9'b0, zrun_err}, 10'd0);
        end
        chk(wtag, out_word, exp_word);
        chk("R8", {9'b0, sync_found}, {9'b0, es});
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_word = '0; std_sel = 1'b0;
        acc = 0; run = 0; gap = 0;
        h0 = '0; h1 = '0; h2 = '0; h3 = '0; exp_word = '0;
        for (int i = 0; i < 3; i++) step(1, 0, 10'h000, 0);

        // every 10-bit value ahead of a zero pair
        for (int c = 0; c < 3072; c++)
            step(0, 1, (c % 3 == 0) ? 10'(c / 3) : 10'h000, 0);

        // mixed words with idle gaps
        for (int c = 0; c < 1024; c++)
            step(0, (c % 4) != 3,
                 (c % 3 == 0) ? 10'(c / 4) : ((c % 3 == 1) ? 10'h000 : 10'h2A5), 0);

        // reset wins over a valid reference-like word
        step(1, 1, 10'h3FC, 0);
        step(1, 1, 10'h3FC, 0);

        // zero runs of 1..6 words, both limits, some gaps inside runs
        for (int c = 0; c < 960; c++) begin
            int sub, len;
            sub = c % 8;
            len = (c / 8) % 6 + 1;
            step(0, (c % 11) != 5,
                 (sub == 0) ? 10'h3FC : ((sub <= len) ? 10'h000 : 10'h155),
                 ((c / 48) % 2) == 1);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule